// File: doc/BRIEF.md
# Cascaded Two-Die Pip Sequencer

This block drives the pip lamps of a pair of electronic dice. Each die is a 4-bit register that steps through a fixed six-state code. The code is chosen so that each bit lights one group of pips directly, with no decoder between register and lamp. The first die moves on every enabled clock. The second die moves only on the clock where the first die wraps from its sixth face back to its first. Together the pair walks all 36 face combinations in a fixed order.

Nothing in the block is random. A roll is made by running the clock fast with the roll enable held high and then dropping the enable at a moment a person cannot time. Each die also reports a face index for logic that wants a number rather than lamp lines.

The next-state equations are self-correcting: every code outside the six-state loop falls back into it within two clocks. A second die that holds an unused code does not wait for a carry; it steps on every enabled clock until it is valid again.

Top module: `dice_roller`

## Requirements
- R1: While `rst` is high at a clock edge, each die loads its parameter reset code. The default is 0100 (face 1) for every die, so with defaults `led_n` reads 8'hBB and `face` reads 6'o11.
- R2: Each valid die state, written as bits [3:0], maps to a face index as follows: 0100 is 1, 0010 is 2, 1100 is 3, 1010 is 4, 1110 is 5 and 1011 is 6. An enabled advance moves a die from face k to face k+1, and from face 6 to face 1.
- R3: Lamp lines are the inverted state bits, active low. Die g owns `led_n[4g+3:4g]`, and `face[3g+2:3g]` carries its face index.
- R4: The second die advances on an enabled edge only when the first die's state bit 0 is 1 (the first die at face 6). Otherwise it holds its value, as long as its own code is valid.
- R5: Starting from any reachable valid pair, 36 consecutive enabled clocks show each of the 36 face combinations exactly once.
- R6: With `roll_en` low and `rst` low, both dice keep their state, so `led_n` and `face` do not change.
- R7: A die holding any of the ten unused codes reports face index 0.
- R8: From any of the 16 codes in both dice, each die reaches a valid code within 3 enabled clocks. A second die with an unused code advances on every enabled clock, whatever the first die's state.
- R9: The reset code of each die is set through the parameter `INIT_CODES`, one 4-bit field per die, with die 0 in the lowest field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all dice |
| rst | input | 1 | Synchronous reset, active high |
| roll_en | input | 1 | High lets the dice advance; low freezes them |
| led_n | output | 4*NUM_DICE (8) | Active-low lamp-group lines, 4 per die |
| face | output | 3*NUM_DICE (6) | Face index per die, 1 to 6, or 0 for an unused code |

## Verification
The main instance uses the defaults: two dice, both reset to face 1. A scoreboard predicts the full 36-step walk, the hold while the enable is low, and a reset in the middle of a run. Alongside it, sixteen more instances are built with `INIT_CODES` set to the same code in both dice, one instance for each of the 16 codes. This is the only way, through the block's normal interface, to start a die in an unused state. It brings the unused-code face index and the bounded recovery of both dice, including the second die's free stepping, within reach of the bench.

// File: rtl/dice_pkg.sv
package dice_pkg;

    localparam int CODE_W = 4;
    localparam int FACE_W = 3;
    localparam int FACES  = 6;

    typedef logic [CODE_W-1:0] pip_code_t;
    typedef logic [FACE_W-1:0] face_t;

    // Six-state loop, in stepping order
    localparam pip_code_t PIP_F1 = 4'b0100;
    localparam pip_code_t PIP_F2 = 4'b0010;
    localparam pip_code_t PIP_F3 = 4'b1100;
    localparam pip_code_t PIP_F4 = 4'b1010;
    localparam pip_code_t PIP_F5 = 4'b1110;
    localparam pip_code_t PIP_F6 = 4'b1011;

    typedef struct packed {
        face_t     face;
        logic      valid;
        pip_code_t led_n;
    } die_view_t;

    // Next-state equations. Kept unminimised so every unused code drains
    // into the loop within two steps.
    function automatic pip_code_t pip_next(input pip_code_t c);
        pip_code_t n;
        n[0] = ~c[0] & c[1] & c[2];
        n[1] = ~c[0] & (c[2] | c[3]);
        n[2] = ~c[2];
        n[3] = ~c[0] & (c[1] | c[3]);
        return n;
    endfunction

    function automatic face_t pip_face(input pip_code_t c);
        face_t f;
        unique case (c)
            PIP_F1:  f = 3'd1;
            PIP_F2:  f = 3'd2;
            PIP_F3:  f = 3'd3;
            PIP_F4:  f = 3'd4;
            PIP_F5:  f = 3'd5;
            PIP_F6:  f = 3'd6;
            default: f = 3'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pip_next_logic.sv
module pip_next_logic
    import dice_pkg::*;
(
    input  pip_code_t code,
    output pip_code_t next_code
);
    always_comb begin
        next_code = pip_next(code);
    end
endmodule

// File: rtl/pip_die_reg.sv
module pip_die_reg
    import dice_pkg::*;
#(
    parameter pip_code_t INIT = PIP_F1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  pip_code_t next_code,
    output pip_code_t code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= INIT;
        end else if (adv) begin
            code <= next_code;
        end
    end
endmodule

// File: rtl/pip_face_view.sv
module pip_face_view
    import dice_pkg::*;
(
    input  pip_code_t code,
    output die_view_t view
);
    always_comb begin
        view.face  = pip_face(code);
        view.valid = (view.face != '0);
        view.led_n = ~code;
    end
endmodule

// File: rtl/dice_carry_link.sv
module dice_carry_link (
    input  logic roll_en,
    input  logic carry_in,
    input  logic valid,
    output logic adv
);
    // An invalid die steps freely so it cannot wait forever on a carry.
    always_comb begin
        adv = roll_en & (carry_in | ~valid);
    end
endmodule

// File: rtl/dice_roller.sv
module dice_roller
    import dice_pkg::*;
#(
    parameter int NUM_DICE = 2,
    parameter logic [NUM_DICE*CODE_W-1:0] INIT_CODES = {NUM_DICE{PIP_F1}},
    localparam int LED_W  = NUM_DICE * CODE_W,
    localparam int FIDX_W = NUM_DICE * FACE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              roll_en,
    output logic [LED_W-1:0]  led_n,
    output logic [FIDX_W-1:0] face
);

    logic [NUM_DICE-1:0] carry;
    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NUM_DICE; g++) begin : g_die
        pip_code_t code_q;
        pip_code_t code_d;
        die_view_t view;
        logic      adv;

        pip_next_logic u_next (
            .code      (code_q),
            .next_code (code_d)
        );

        pip_die_reg #(
            .INIT (INIT_CODES[g*CODE_W +: CODE_W])
        ) u_reg (
            .clk       (clk),
            .rst       (rst),
            .adv       (adv),
            .next_code (code_d),
            .code      (code_q)
        );

        pip_face_view u_view (
            .code (code_q),
            .view (view)
        );

        dice_carry_link u_link (
            .roll_en  (roll_en),
            .carry_in (carry[g]),
            .valid    (view.valid),
            .adv      (adv)
        );

        if (g < NUM_DICE - 1) begin : g_chain
            // Bit 0 is set only in face 6, the step that wraps this die.
            assign carry[g+1] = carry[g] & code_q[0];
        end

        assign led_n[g*CODE_W +: CODE_W] = view.led_n;
        assign face[g*FACE_W +: FACE_W]  = view.face;
    end

endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk
    import dice_pkg::*;
#(
    parameter int NUM_DICE = 2,
    localparam int LED_W  = NUM_DICE * CODE_W,
    localparam int FIDX_W = NUM_DICE * FACE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              roll_en,
    input logic [LED_W-1:0]  led_n,
    input logic [FIDX_W-1:0] face
);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !roll_en |=> ($stable(led_n) && $stable(face)));

    // R2
    face_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (roll_en && face[2:0] == 3'd6) |=> (face[2:0] == 3'd1));

    // R2
    face_step_chk: assert property (@(posedge clk) disable iff (rst)
        (roll_en && face[2:0] != 3'd0 && face[2:0] != 3'd6)
        |=> (face[2:0] == $past(face[2:0]) + 3'd1));

    // R7
    face_range_chk: assert property (@(posedge clk) disable iff (rst)
        face[2:0] != 3'd7);

    if (NUM_DICE > 1) begin : g_second
        // R4
        second_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (led_n[0] && face[5:3] != 3'd0) |=> $stable(led_n[7:4]));
    end

    for (genvar g = 0; g < NUM_DICE; g++) begin : g_run
        logic [1:0] run;
        always_ff @(posedge clk) begin
            if (rst) begin
                run <= 2'd0;
            end else if (roll_en) begin
                if (face[g*FACE_W +: FACE_W] == '0) begin
                    run <= (run == 2'd3) ? run : run + 2'd1;
                end else begin
                    run <= 2'd0;
                end
            end
        end
        // R8
        recover_bound_chk: assert property (@(posedge clk) disable iff (rst)
            run != 2'd3);
    end

endmodule

bind dice_roller dice_roller_chk #(.NUM_DICE(NUM_DICE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .roll_en (roll_en),
    .led_n   (led_n),
    .face    (face)
);

// File: tb/sim_dice_roller.sv
module sim_dice_roller;

    typedef struct {
        int    fa;
        int    fb;
        bit    cnt;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       roll_en = 1'b0;
    logic [7:0] led_n;
    logic [5:0] face;

    logic [7:0] rled  [16];
    logic [5:0] rface [16];

    int   checks = 0;
    int   failures = 0;
    int   pos = 0;
    int   seen [36];
    bit   done = 1'b0;
    exp_t q [$];

    always #2 clk = ~clk;

    dice_roller u0 (
        .clk     (clk),
        .rst     (rst),
        .roll_en (roll_en),
        .led_n   (led_n),
        .face    (face)
    );

    for (genvar k = 0; k < 16; k++) begin : g_rec
        dice_roller #(
            .NUM_DICE   (2),
            .INIT_CODES ({2{4'(k)}})
        ) u_rec (
            .clk     (clk),
            .rst     (rst),
            .roll_en (roll_en),
            .led_n   (rled[k]),
            .face    (rface[k])
        );
    end

    function automatic logic [3:0] code_of(input int f);
        case (f)
            1: return 4'b0100;
            2: return 4'b0010;
            3: return 4'b1100;
            4: return 4'b1010;
            5: return 4'b1110;
            6: return 4'b1011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int face_of(input logic [3:0] c);
        for (int f = 1; f <= 6; f++) begin
            if (code_of(f) == c) return f;
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic r, input bit cnt, input string tag);
        exp_t e;
        roll_en = en;
        rst     = r;
        @(posedge clk);
        if (r) pos = 0;
        else if (en) pos = (pos + 1) % 36;
        e.fa  = pos % 6 + 1;
        e.fb  = pos / 6 + 1;
        e.cnt = cnt;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        exp_t e;
        int   fa;
        int   fb;
        int   lexp;
        if (q.size() > 0) begin
            e    = q.pop_front();
            fa   = int'(face[2:0]);
            fb   = int'(face[5:3]);
            lexp = int'({~code_of(e.fb), ~code_of(e.fa)});
            check(fa == e.fa, {e.tag, " die0 face"}, fa, e.fa);
            check(fb == e.fb, {e.tag, " die1 face"}, fb, e.fb);
            check(int'(led_n) == lexp, {e.tag, " R3 led_n"}, int'(led_n), lexp);
            if (e.cnt && fa >= 1 && fa <= 6 && fb >= 1 && fb <= 6)
                seen[(fa - 1) * 6 + (fb - 1)]++;
        end
    end

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(4 * 60000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R1 reset");

        // R9, R7, R3: parameter reset codes seen at the ports
        for (int k = 0; k < 16; k++) begin
            check(int'(rface[k][2:0]) == face_of(4'(k)), "R7 R9 die0 init face",
                  int'(rface[k][2:0]), face_of(4'(k)));
            check(int'(rface[k][5:3]) == face_of(4'(k)), "R7 R9 die1 init face",
                  int'(rface[k][5:3]), face_of(4'(k)));
            check(rled[k] == ~{4'(k), 4'(k)}, "R3 R9 init led_n",
                  int'(rled[k]), int'(~{4'(k), 4'(k)}));
        end

        // R8: recovery within 3 enabled clocks
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R2 R4 walk");
        for (int k = 0; k < 16; k++) begin
            check(rface[k][2:0] != 3'd0, "R8 die0 recovered", int'(rface[k][2:0]), 1);
            check(rface[k][5:3] != 3'd0, "R8 die1 recovered", int'(rface[k][5:3]), 1);
        end

        // R5: full cycle of combinations
        for (int i = 0; i < 36; i++) seen[i] = 0;
        for (int i = 0; i < 36; i++) step(1'b1, 1'b0, 1'b1, "R2 R4 R5 cycle");
        #1;
        for (int i = 0; i < 36; i++)
            check(seen[i] == 1, "R5 combination count", seen[i], 1);

        // R6: hold with enable low
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R6 hold");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R2 R4 walk");

        // R1: reset in mid-run
        step(1'b1, 1'b1, 1'b0, "R1 midrun reset");
        for (int i = 0; i < 45; i++)
            step((i % 3) != 0, 1'b0, 1'b0, "R2 R4 R6 gapped");

        #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule